// File: doc/BRIEF.md
# Compare-Branch Fusion and Packing Stage

This stage sits on the decode side of an instruction pipeline. Each transfer carries a group of up to four pre-decoded slots. Every slot has a valid bit, a two-bit operation class, two operand fields, a condition code and a branch target field. Where a compare sits directly in front of a conditional jump in the same group, the stage merges the two into a single fused compare-and-branch operation. Every other valid slot goes through unchanged. The surviving operations are packed toward output slot 0, so a group that held fusions sends fewer entries downstream.

A `mode64` input turns fusion off completely. While it is high when a group is accepted, every valid slot leaves as its own operation. Both data interfaces use valid/ready, and each transfer moves a whole group. An input group is accepted on a rising edge where `in_valid && in_ready`. `in_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). A presented output group stays in the register, unchanged, until `out_ready` takes it. A partial group is never emitted.

Class encoding: 0 = other, 1 = compare, 2 = conditional jump, 3 = fused. Slot i of every flat bus sits at bits `[i*W +: W]`.

Top module: `cmpbr_fuse_stage`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready` at all times after reset. One group of up to four slots is taken per handshake.
- R2: When fusion is enabled, a valid slot i of class 1 (compare) followed by a valid slot i+1 of class 2 (jump) becomes one output of class 3 with its fused bit set. All other valid slots keep their class, including class 3 at the input, and have the fused bit clear.
- R3: A fused output carries the compare's two operand fields and the jump's condition code and target field. An unfused output carries its own slot's fields unchanged.
- R4: When `mode64` is high at acceptance, no fusion takes place and every valid slot is emitted on its own.
- R5: Pairs are formed scanning from slot 0 upward. A jump that has already joined a pair cannot start or join another. For example, compare, compare, jump, jump gives compare, fused, jump.
- R6: Fusion never crosses groups. A compare in slot 3 and a jump in slot 0 of the next group stay two separate operations.
- R7: The valid outputs occupy slots 0 upward with no gaps and keep the input order. Invalid input slots are dropped, and a slot that is not valid does not count as a neighbour for pairing.
- R8: The number of valid outputs equals the number of valid input slots minus the number of fusions.
- R9: An accepted group appears at the output on the next clock edge. While `out_valid` is high and `out_ready` is low, the output group holds every bit.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | High disables fusion for the group being accepted |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Stage can take a group |
| in_slot_vld | input | LANES | Per-slot valid bits |
| in_cls | input | LANES*2 | Per-slot class |
| in_opa | input | LANES*OPW | Per-slot first operand |
| in_opb | input | LANES*OPW | Per-slot second operand |
| in_cond | input | LANES*CW | Per-slot condition code |
| in_tgt | input | LANES*TW | Per-slot target field |
| out_valid | output | 1 | Output group present |
| out_ready | input | 1 | Consumer takes the output group |
| out_slot_vld | output | LANES | Packed per-slot valid bits |
| out_fused | output | LANES | Per-slot fused marker |
| out_cls | output | LANES*2 | Per-slot class |
| out_opa | output | LANES*OPW | Per-slot first operand |
| out_opb | output | LANES*OPW | Per-slot second operand |
| out_cond | output | LANES*CW | Per-slot condition code |
| out_tgt | output | LANES*TW | Per-slot target field |

## Verification
The stage has one register, so every result of a group accepted on edge N is due at the output from edge N+1 onward. It stays there until the edge on which `out_ready` is seen high. The reference model takes each handshake at the falling edge before that handshake's rising edge, and queues the expected group from the inputs it sees there. The model then compares the queue front with the outputs at every falling edge while `out_valid` is high, so a stalled group is compared again on each held cycle. `in_ready` and `out_valid` are compared on the same falling edges against the queue depth and `out_ready`.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    OP_OTHER = 2'd0,
    OP_CMP   = 2'd1,
    OP_JCC   = 2'd2,
    OP_FUSED = 2'd3
  } op_cls_e;
endpackage

// File: rtl/cmpbr_pair_detect.sv
module cmpbr_pair_detect
  import cmpbr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]       vld,
  input  logic [LANES*CLS_W-1:0] cls,
  input  logic                   mode64,
  output logic [LANES-1:0]       start,
  output logic [LANES-1:0]       lead
);
  logic [LANES-1:0] cand;

  // a lane is a pair candidate when it and its upper neighbour form cmp+jcc
  for (genvar g = 0; g < LANES; g++) begin : g_cand
    if (g == LANES - 1) begin : g_last
      assign cand[g] = 1'b0;
    end else begin : g_mid
      assign cand[g] = !mode64 && vld[g] && vld[g+1] &&
                       (cls[g*CLS_W +: CLS_W] == OP_CMP) &&
                       (cls[(g+1)*CLS_W +: CLS_W] == OP_JCC);
    end
  end

  // scan upward: a lane consumed as the jump half neither leads nor starts
  logic taken;
  always_comb begin
    start = '0;
    lead  = '0;
    taken = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      lead[i]  = vld[i] && !taken;
      start[i] = cand[i] && !taken;
      taken    = start[i];
    end
  end
endmodule

// File: rtl/cmpbr_merge.sv
module cmpbr_merge
  import cmpbr_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 4,
  parameter int TW    = 8
) (
  input  logic [LANES-1:0]       start,
  input  logic [LANES*CLS_W-1:0] cls,
  input  logic [LANES*CW-1:0]    cond,
  input  logic [LANES*TW-1:0]    tgt,
  output logic [LANES*CLS_W-1:0] m_cls,
  output logic [LANES*CW-1:0]    m_cond,
  output logic [LANES*TW-1:0]    m_tgt
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < LANES - 1) begin : g_pairable
      assign m_cls[g*CLS_W +: CLS_W] = start[g] ? OP_FUSED : cls[g*CLS_W +: CLS_W];
      assign m_cond[g*CW +: CW] = start[g] ? cond[(g+1)*CW +: CW] : cond[g*CW +: CW];
      assign m_tgt[g*TW +: TW]  = start[g] ? tgt[(g+1)*TW +: TW]  : tgt[g*TW +: TW];
    end else begin : g_top
      assign m_cls[g*CLS_W +: CLS_W] = cls[g*CLS_W +: CLS_W];
      assign m_cond[g*CW +: CW]      = cond[g*CW +: CW];
      assign m_tgt[g*TW +: TW]       = tgt[g*TW +: TW];
    end
  end

  logic unused_start_top;
  assign unused_start_top = start[LANES-1];
endmodule

// File: rtl/cmpbr_pack.sv
module cmpbr_pack #(
  parameter int LANES = 4,
  parameter int RW    = 8
) (
  input  logic [LANES-1:0]    lead,
  input  logic [LANES*RW-1:0] rec,
  output logic [LANES-1:0]    pk_vld,
  output logic [LANES*RW-1:0] pk_rec
);
  int pos;
  always_comb begin
    pk_vld = '0;
    pk_rec = '0;
    pos    = 0;
    for (int i = 0; i < LANES; i++) begin
      if (lead[i]) begin
        for (int j = 0; j < LANES; j++) begin
          if (j == pos) begin
            pk_rec[j*RW +: RW] = rec[i*RW +: RW];
            pk_vld[j]          = 1'b1;
          end
        end
        pos = pos + 1;
      end
    end
  end
endmodule

// File: rtl/cmpbr_fuse_stage.sv
module cmpbr_fuse_stage
  import cmpbr_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OPW   = 8,
  parameter int CW    = 4,
  parameter int TW    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode64,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES-1:0]       in_slot_vld,
  input  logic [LANES*CLS_W-1:0] in_cls,
  input  logic [LANES*OPW-1:0]   in_opa,
  input  logic [LANES*OPW-1:0]   in_opb,
  input  logic [LANES*CW-1:0]    in_cond,
  input  logic [LANES*TW-1:0]    in_tgt,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES-1:0]       out_slot_vld,
  output logic [LANES-1:0]       out_fused,
  output logic [LANES*CLS_W-1:0] out_cls,
  output logic [LANES*OPW-1:0]   out_opa,
  output logic [LANES*OPW-1:0]   out_opb,
  output logic [LANES*CW-1:0]    out_cond,
  output logic [LANES*TW-1:0]    out_tgt
);
  // record per lane: {fused, cls, opa, opb, cond, tgt}
  localparam int O_TGT = 0;
  localparam int O_CND = O_TGT + TW;
  localparam int O_OPB = O_CND + CW;
  localparam int O_OPA = O_OPB + OPW;
  localparam int O_CLS = O_OPA + OPW;
  localparam int O_FUS = O_CLS + CLS_W;
  localparam int RW    = O_FUS + 1;

  logic                   accept;
  logic [LANES-1:0]       start, lead;
  logic [LANES*CLS_W-1:0] m_cls;
  logic [LANES*CW-1:0]    m_cond;
  logic [LANES*TW-1:0]    m_tgt;
  logic [LANES*RW-1:0]    rec, pk_rec, q_rec;
  logic [LANES-1:0]       pk_vld, q_vld;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  cmpbr_pair_detect #(.LANES(LANES)) u_detect (
    .vld(in_slot_vld), .cls(in_cls), .mode64(mode64),
    .start(start), .lead(lead)
  );

  cmpbr_merge #(.LANES(LANES), .CW(CW), .TW(TW)) u_merge (
    .start(start), .cls(in_cls), .cond(in_cond), .tgt(in_tgt),
    .m_cls(m_cls), .m_cond(m_cond), .m_tgt(m_tgt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_rec
    assign rec[g*RW +: RW] = {start[g], m_cls[g*CLS_W +: CLS_W],
                              in_opa[g*OPW +: OPW], in_opb[g*OPW +: OPW],
                              m_cond[g*CW +: CW], m_tgt[g*TW +: TW]};
  end

  cmpbr_pack #(.LANES(LANES), .RW(RW)) u_pack (
    .lead(lead), .rec(rec), .pk_vld(pk_vld), .pk_rec(pk_rec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_vld     <= '0;
      q_rec     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      q_vld     <= pk_vld;
      q_rec     <= pk_rec;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign out_slot_vld[g]             = q_vld[g];
    assign out_fused[g]                = q_rec[g*RW + O_FUS];
    assign out_cls[g*CLS_W +: CLS_W]   = q_rec[g*RW + O_CLS +: CLS_W];
    assign out_opa[g*OPW +: OPW]       = q_rec[g*RW + O_OPA +: OPW];
    assign out_opb[g*OPW +: OPW]       = q_rec[g*RW + O_OPB +: OPW];
    assign out_cond[g*CW +: CW]        = q_rec[g*RW + O_CND +: CW];
    assign out_tgt[g*TW +: TW]         = q_rec[g*RW + O_TGT +: TW];
  end

  // group is emitted one edge after it is taken
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // a stalled group holds every bit
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_rec) && $stable(out_slot_vld)));

  // valid outputs are contiguous from slot 0
  assert_packed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_slot_vld & (out_slot_vld + 1'b1)) == '0));

  // fused marker only on a valid output slot
  assert_fused_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_fused & ~out_slot_vld) == '0));

  // no fusion in 64-bit mode
  assert_no_fuse64_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode64) |=> (out_fused == '0));

  // every fusion removes exactly one entry
  assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ($countones(out_slot_vld) + $countones(out_fused) ==
                $past($countones(in_slot_vld))));
endmodule

// File: tb/cmpbr_fuse_stage_tb.sv
module cmpbr_fuse_stage_tb;
  localparam int L = 4, OPW = 8, CW = 4, TW = 8;

  logic clk = 1'b0, rst_n = 1'b0, mode64 = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [L-1:0] in_slot_vld = '0, out_slot_vld, out_fused;
  logic [L*2-1:0] in_cls = '0, out_cls;
  logic [L*OPW-1:0] in_opa = '0, in_opb = '0, out_opa, out_opb;
  logic [L*CW-1:0] in_cond = '0, out_cond;
  logic [L*TW-1:0] in_tgt = '0, out_tgt;

  always #2 clk = ~clk;

  cmpbr_fuse_stage #(.LANES(L), .OPW(OPW), .CW(CW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode64(mode64),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_slot_vld(in_slot_vld), .in_cls(in_cls), .in_opa(in_opa), .in_opb(in_opb),
    .in_cond(in_cond), .in_tgt(in_tgt),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_slot_vld(out_slot_vld), .out_fused(out_fused), .out_cls(out_cls),
    .out_opa(out_opa), .out_opb(out_opb), .out_cond(out_cond), .out_tgt(out_tgt)
  );

  typedef struct {
    int    n;
    int    vld[L];
    int    fz[L];
    int    cls[L];
    int    opa[L];
    int    opb[L];
    int    cond[L];
    int    tgt[L];
    bit    m64;
    string tag;
  } grp_t;

  grp_t  q[$];
  int    n_chk = 0, n_bad = 0;
  int    rdy_mode = 0;
  string cur_tag = "R2";
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: walk the slots, pair cmp followed by jcc
  function automatic grp_t model(input string tag);
    grp_t g;
    int v[L], c[L];
    int i, o;
    for (int k = 0; k < L; k++) begin
      v[k] = int'(in_slot_vld[k +: 1]);
      c[k] = int'(in_cls[k*2 +: 2]);
      g.vld[k] = 0; g.fz[k] = 0; g.cls[k] = 0; g.opa[k] = 0;
      g.opb[k] = 0; g.cond[k] = 0; g.tgt[k] = 0;
    end
    g.m64 = mode64;
    g.tag = tag;
    i = 0;
    o = 0;
    while (i < L) begin
      if (v[i] == 0) begin
        i++;
      end else begin
        g.vld[o]  = 1;
        g.opa[o]  = int'(in_opa[i*OPW +: OPW]);
        g.opb[o]  = int'(in_opb[i*OPW +: OPW]);
        if (!g.m64 && i < L-1 && v[i+1] == 1 && c[i] == 1 && c[i+1] == 2) begin
          g.fz[o]   = 1;
          g.cls[o]  = 3;
          g.cond[o] = int'(in_cond[(i+1)*CW +: CW]);
          g.tgt[o]  = int'(in_tgt[(i+1)*TW +: TW]);
          i += 2;
        end else begin
          g.cls[o]  = c[i];
          g.cond[o] = int'(in_cond[i*CW +: CW]);
          g.tgt[o]  = int'(in_tgt[i*TW +: TW]);
          i += 1;
        end
        o++;
      end
    end
    g.n = o;
    return g;
  endfunction

  // monitor on the falling edge: compare, then book the coming handshakes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(in_ready == (!out_valid || out_ready), "R1", "in_ready",
            int'(in_ready), int'(!out_valid || out_ready));
      check(out_valid == (q.size() > 0), "R9", "out_valid", int'(out_valid),
            int'(q.size() > 0));
      if (out_valid && q.size() > 0) begin
        grp_t e;
        string ft;
        e  = q[0];
        ft = e.m64 ? "R4" : "R2";
        check($countones(out_slot_vld) == e.n, "R8", {e.tag, " count"},
              $countones(out_slot_vld), e.n);
        for (int j = 0; j < L; j++) begin
          check(int'(out_slot_vld[j +: 1]) == e.vld[j], "R7", {e.tag, " slot valid"},
                int'(out_slot_vld[j +: 1]), e.vld[j]);
          check(int'(out_fused[j +: 1]) == e.fz[j], ft, {e.tag, " fused"},
                int'(out_fused[j +: 1]), e.fz[j]);
          if (e.vld[j] == 1) begin
            check(int'(out_cls[j*2 +: 2]) == e.cls[j], ft, {e.tag, " class"},
                  int'(out_cls[j*2 +: 2]), e.cls[j]);
            check(int'(out_opa[j*OPW +: OPW]) == e.opa[j], "R3", {e.tag, " opa"},
                  int'(out_opa[j*OPW +: OPW]), e.opa[j]);
            check(int'(out_opb[j*OPW +: OPW]) == e.opb[j], "R3", {e.tag, " opb"},
                  int'(out_opb[j*OPW +: OPW]), e.opb[j]);
            check(int'(out_cond[j*CW +: CW]) == e.cond[j], "R3", {e.tag, " cond"},
                  int'(out_cond[j*CW +: CW]), e.cond[j]);
            check(int'(out_tgt[j*TW +: TW]) == e.tgt[j], "R3", {e.tag, " tgt"},
                  int'(out_tgt[j*TW +: TW]), e.tgt[j]);
          end
        end
      end
      if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
      if (in_valid && in_ready) q.push_back(model(cur_tag));
    end
  end

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom_range(0, 2) != 0);
      default: out_ready = 1'b0;
    endcase
  end

  task automatic send(input logic [L-1:0] v, input logic [L*2-1:0] c,
                      input logic m, input string tag);
    bit acc;
    cur_tag     = tag;
    in_valid    = 1'b1;
    in_slot_vld = v;
    in_cls      = c;
    mode64      = m;
    for (int k = 0; k < L; k++) begin
      in_opa[k*OPW +: OPW] = OPW'($urandom);
      in_opb[k*OPW +: OPW] = OPW'($urandom);
      in_cond[k*CW +: CW]  = CW'($urandom);
      in_tgt[k*TW +: TW]   = TW'($urandom);
    end
    do begin
      @(negedge clk);
      acc = in_valid && in_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // class codes per slot, slot 0 in the low bits: 0 other, 1 cmp, 2 jcc, 3 fused
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10", "in_ready in reset", int'(in_ready), 1);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    send(4'b1111, {2'd0, 2'd0, 2'd2, 2'd1}, 1'b0, "R2 cmp-jcc slot0");
    send(4'b1111, {2'd0, 2'd0, 2'd2, 2'd1}, 1'b1, "R4 64-bit no fuse");
    send(4'b1111, {2'd2, 2'd2, 2'd1, 2'd1}, 1'b0, "R5 cmp cmp jcc jcc");
    send(4'b1111, {2'd2, 2'd1, 2'd2, 2'd1}, 1'b0, "R5 two pairs");
    send(4'b1111, {2'd2, 2'd1, 2'd2, 2'd1}, 1'b1, "R4 two pairs 64-bit");
    send(4'b1111, {2'd1, 2'd0, 2'd0, 2'd0}, 1'b0, "R6 cmp in slot 3");
    send(4'b1111, {2'd0, 2'd0, 2'd0, 2'd2}, 1'b0, "R6 jcc in next slot 0");
    send(4'b0101, {2'd0, 2'd2, 2'd2, 2'd1}, 1'b0, "R7 gap breaks pair");
    send(4'b0110, {2'd0, 2'd2, 2'd1, 2'd0}, 1'b0, "R7 pair after empty slot");
    send(4'b0000, {2'd2, 2'd1, 2'd2, 2'd1}, 1'b0, "R7 empty group");
    send(4'b1111, {2'd3, 2'd3, 2'd0, 2'd3}, 1'b0, "R2 class 3 passes");
    send(4'b1100, {2'd2, 2'd1, 2'd0, 2'd0}, 1'b0, "R8 upper pair");
    // R9: hold under back-pressure
    rdy_mode = 2;
    repeat (2) @(posedge clk);
    #1;
    send(4'b1011, {2'd2, 2'd0, 2'd2, 2'd1}, 1'b0, "R9 held group");
    repeat (6) @(posedge clk);
    #1;
    rdy_mode = 0;
    // R1: random traffic with random back-pressure
    rdy_mode = 1;
    for (int r = 0; r < 400; r++) begin
      logic [L*2-1:0] c;
      c = ($urandom_range(0, 1) == 0) ? {2'd2, 2'd1, 2'd2, 2'd1} : (L*2)'($urandom);
      send(L'($urandom), c, ($urandom_range(0, 3) == 0), "R1 random");
    end
    rdy_mode = 0;
    while (q.size() > 0 || out_valid) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule